// File: doc/BRIEF.md
# Daisy-Chainable Serial Code Latch

This block is the digital front end of a 128-step variable resistor. A host writes a 7-bit wiper code over a three-wire serial link made of a serial clock, an active-low select and a data line. Each bit goes into a shift register. When the select line is released, the register contents move into a separate code latch, and that latch drives the resistor decoder. The far end of the shift register drives a serial output with an output enable, so several devices can share one link in a chain.

All serial and control inputs are asynchronous to the system clock. A faster system clock samples each of them through a two-flop synchronizer, and the block detects their edges on that clock. The serial clock must run below a quarter of the system clock rate. A change on an input affects the registered state on the third system clock edge after the change.

A preset input loads the midscale code. A sleep input does the following:
- raises the flags that open the A terminal and tie the wiper to B;
- releases the serial output;
- keeps the stored code;
- leaves the serial link working.

Top module: `ser_code_latch`

## Requirements
- R1: After `rst_ni` is released, the outputs are: `code_o` = 0x40, `open_a_o` = 0, `wiper_b_o` = 0, `sdo_oe_o` = 0, `sdo_o` = 1 and `code_upd_o` = 0. The shift register is cleared to all zeros.
- R2: While `csn_i` is low, each rising edge of `sclk_i` shifts `sdi_i` into bit 0 of the shift register. Every stored bit moves one place toward bit 6.
- R3: A rising edge of `csn_i` copies the shift register into `code_o`. The bit shifted in seventh from last becomes bit 6, and the last bit becomes bit 0. In a word longer than seven bits, all earlier bits are dropped.
- R4: When enabled, `sdo_o` shows shift-register bit 6, which is the bit shifted in seven edges earlier. Two chained devices therefore take a 14-bit frame. `sdo_oe_o` turns on at the first shift made while preset is inactive. While `sdo_oe_o` is low, `sdo_o` reads 1.
- R5: While `csn_i` is high, `sclk_i` edges have no effect. The code, the shift register and `sdo_o` hold their values.
- R6: While `preset_ni` is low, `code_o` is 0x40 and `sdo_oe_o` is 0. The output stays released until a shift happens after preset is released.
- R7: If preset is active in the same cycle as a `csn_i` rising edge, the preset wins and `code_o` stays 0x40. While preset is held, a transfer is ignored.
- R8: While `sleep_ni` is low, the outputs are: `open_a_o` = 1, `wiper_b_o` = 1, `sdo_oe_o` = 0 and `sdo_o` = 1. `code_o` keeps its value.
- R9: A transfer made during sleep updates `code_o`. That code remains in place after sleep ends.
- R10: `code_upd_o` pulses for exactly one cycle in two cases: on each transfer with preset inactive, and on entry into preset. It stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| sclk_i | input | 1 | Serial clock, rising edge shifts |
| csn_i | input | 1 | Active-low serial select; its rising edge transfers |
| sdi_i | input | 1 | Serial data in |
| preset_ni | input | 1 | Active-low midscale preset |
| sleep_ni | input | 1 | Active-low shutdown |
| code_o | output | 7 | Latched wiper code |
| code_upd_o | output | 1 | One-cycle pulse on each latch write |
| open_a_o | output | 1 | Open-A-terminal flag |
| wiper_b_o | output | 1 | Wiper-to-B flag |
| sdo_o | output | 1 | Serial data out (1 when released) |
| sdo_oe_o | output | 1 | Serial output enable |

## Verification
Directed frames exercise the transfer rule at three lengths, each separating a different fault:
- Exactly seven bits catch bit-order errors.
- Longer words show whether earlier bits are dropped.
- Short words show that residue from earlier frames is kept.

A 14-bit frame checks `sdo_o` after every edge, which tells a seven-deep delay apart from an off-by-one depth. Clock pulses with select high tell a correct hold apart from a leaky shift. Random frames mix random preset and sleep episodes, covering transfers during sleep, a preset that coincides with a transfer, and re-arming of the output after preset.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int unsigned IN_SCLK = 0;
  localparam int unsigned IN_CSN  = 1;
  localparam int unsigned IN_SDI  = 2;
  localparam int unsigned IN_PRE  = 3;
  localparam int unsigned IN_SLP  = 4;
  localparam int unsigned IN_W    = 5;
  // idle levels: select, preset and sleep high
  localparam logic [IN_W-1:0] IN_IDLE = 5'b11010;

  function automatic logic [15:0] mid_code(input int unsigned w);
    return 16'(1) << (w - 1);
  endfunction
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int unsigned     WIDTH   = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= RST_VAL;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/scl_shreg.sv
module scl_shreg #(
  parameter int unsigned CODE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              sdi_i,
  input  logic              clr_i,
  input  logic              sleep_i,
  output logic [CODE_W-1:0] sr_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic [CODE_W-1:0] sr_q;
  logic              armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[CODE_W-2:0], sdi_i};
  end

  // output stage re-arms on the first shift after a preset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (clr_i)   armed_q <= 1'b0;
    else if (shift_i) armed_q <= 1'b1;
  end

  assign sr_o     = sr_q;
  assign sdo_oe_o = armed_q & ~sleep_i;
  assign sdo_o    = sdo_oe_o ? sr_q[CODE_W-1] : 1'b1;
endmodule

// File: rtl/scl_store.sv
module scl_store #(
  parameter int unsigned CODE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              preset_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o,
  output logic              upd_o
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(scl_pkg::mid_code(CODE_W));

  logic [CODE_W-1:0] code_q;
  logic              upd_q;
  logic              pre_d_q;
  logic              pre_entry;

  assign pre_entry = preset_i & ~pre_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= MID;
      upd_q   <= 1'b0;
      pre_d_q <= 1'b0;
    end else begin
      pre_d_q <= preset_i;
      upd_q   <= pre_entry | (load_i & ~preset_i);
      if (preset_i)    code_q <= MID;
      else if (load_i) code_q <= data_i;
    end
  end

  assign code_o = code_q;
  assign upd_o  = upd_q;
endmodule

// File: rtl/ser_code_latch.sv
module ser_code_latch #(
  parameter int unsigned CODE_W = 7,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              sdi_i,
  input  logic              preset_ni,
  input  logic              sleep_ni,
  output logic [CODE_W-1:0] code_o,
  output logic              code_upd_o,
  output logic              open_a_o,
  output logic              wiper_b_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  import scl_pkg::*;

  logic [IN_W-1:0]   raw_in, syn_in;
  logic              sclk_d_q, csn_d_q, sleep_q;
  logic              sclk_rise, cs_rise, preset_act, sleep_act;
  logic [CODE_W-1:0] sr;

  assign raw_in[IN_SCLK] = sclk_i;
  assign raw_in[IN_CSN]  = csn_i;
  assign raw_in[IN_SDI]  = sdi_i;
  assign raw_in[IN_PRE]  = preset_ni;
  assign raw_in[IN_SLP]  = sleep_ni;

  scl_sync #(.WIDTH(IN_W), .STAGES(SYNC_N), .RST_VAL(IN_IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      csn_d_q  <= 1'b1;
      sleep_q  <= 1'b0;
    end else begin
      sclk_d_q <= syn_in[IN_SCLK];
      csn_d_q  <= syn_in[IN_CSN];
      sleep_q  <= sleep_act;
    end
  end

  assign sclk_rise  = syn_in[IN_SCLK] & ~sclk_d_q & ~syn_in[IN_CSN];
  assign cs_rise    = syn_in[IN_CSN] & ~csn_d_q;
  assign preset_act = ~syn_in[IN_PRE];
  assign sleep_act  = ~syn_in[IN_SLP];

  scl_shreg #(.CODE_W(CODE_W)) u_shreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (sclk_rise),
    .sdi_i   (syn_in[IN_SDI]),
    .clr_i   (preset_act),
    .sleep_i (sleep_q),
    .sr_o    (sr),
    .sdo_o   (sdo_o),
    .sdo_oe_o(sdo_oe_o)
  );

  scl_store #(.CODE_W(CODE_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cs_rise),
    .preset_i(preset_act),
    .data_i  (sr),
    .code_o  (code_o),
    .upd_o   (code_upd_o)
  );

  assign open_a_o  = sleep_q;
  assign wiper_b_o = sleep_q;
endmodule

// File: rtl/scl_chk.sv
module scl_chk #(
  parameter int unsigned CODE_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] code_o,
  input logic              code_upd_o,
  input logic              open_a_o,
  input logic              wiper_b_o,
  input logic              sdo_oe_o,
  input logic              preset_act,
  input logic              sleep_act,
  input logic              cs_rise
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(scl_pkg::mid_code(CODE_W));

  p_preset_mid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_act |=> code_o == MID);

  p_preset_oe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_act |=> !sdo_oe_o);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_rise && !preset_act) |=> $stable(code_o));

  p_upd_mark_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> code_upd_o);

  p_upd_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_upd_o |-> $past(cs_rise || preset_act));

  p_sleep_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_act |=> (open_a_o && wiper_b_o && !sdo_oe_o));
endmodule

bind ser_code_latch scl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .code_o    (code_o),
  .code_upd_o(code_upd_o),
  .open_a_o  (open_a_o),
  .wiper_b_o (wiper_b_o),
  .sdo_oe_o  (sdo_oe_o),
  .preset_act(preset_act),
  .sleep_act (sleep_act),
  .cs_rise   (cs_rise)
);

// File: tb/ser_code_latch_bench.sv
`timescale 1ns/1ps
module ser_code_latch_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, csn = 1'b1, sdi = 1'b0, pre_n = 1'b1, slp_n = 1'b1;
  logic [6:0] code;
  logic       upd, open_a, wiper_b, sdo, sdo_oe;

  int total = 0, bad = 0, upd_cnt = 0;

  logic [6:0] m_sr = '0, m_code = 7'h40;
  bit         m_armed = 0, m_sleep = 0, m_pre = 0;

  always #4 clk = ~clk;

  always @(negedge clk) if (rst_n && upd) upd_cnt++;

  ser_code_latch u_ser_code_latch (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
    .preset_ni(pre_n), .sleep_ni(slp_n), .code_o(code), .code_upd_o(upd),
    .open_a_o(open_a), .wiper_b_o(wiper_b), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  function automatic logic exp_sdo();
    return (m_armed && !m_sleep) ? m_sr[6] : 1'b1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sclk(input logic b);
    sdi = b;
    wait_n(4);
    sclk = 1'b1;
    wait_n(5);
    if (!csn) begin
      m_sr = {m_sr[5:0], b};
      if (!m_pre) m_armed = 1;
    end
    check("R2/R4 sdo", sdo, exp_sdo());
    check("R4 sdo_oe", sdo_oe, int'(m_armed && !m_sleep));
    sclk = 1'b0;
    wait_n(4);
  endtask

  task automatic frame(input int n, input logic [31:0] bits);
    int c0;
    csn = 1'b0;
    wait_n(4);
    for (int i = n - 1; i >= 0; i--) pulse_sclk(bits[i]);
    c0 = upd_cnt;
    csn = 1'b1;
    wait_n(6);
    if (!m_pre) m_code = m_sr;
    check("R3/R9 code", code, m_code);
    check("R10 upd count", upd_cnt - c0, m_pre ? 0 : 1);
  endtask

  task automatic set_sleep(input bit s);
    slp_n = !s;
    m_sleep = s;
    wait_n(6);
    check("R8 open_a", open_a, s);
    check("R8 wiper_b", wiper_b, s);
    check("R8 sdo", sdo, exp_sdo());
    check("R8 code kept", code, m_code);
  endtask

  task automatic set_preset(input bit p);
    int c0;
    c0 = upd_cnt;
    pre_n = !p;
    if (p) begin
      m_pre = 1;
      m_code = 7'h40;
      m_armed = 0;
    end else m_pre = 0;
    wait_n(6);
    check("R6 code", code, m_code);
    check("R6 sdo_oe", sdo_oe, 0);
    check("R10 preset upd", upd_cnt - c0, p ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    int          c0;
    logic [6:0]  keep;
    seed_dummy = $urandom(32'h5eed);
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);
    // R1 reset state
    check("R1 code", code, 7'h40);
    check("R1 open_a", open_a, 0);
    check("R1 wiper_b", wiper_b, 0);
    check("R1 sdo_oe", sdo_oe, 0);
    check("R1 sdo", sdo, 1);
    check("R1 upd", upd_cnt, 0);

    // R3 exact, long and short words
    frame(7, 32'h55);
    frame(7, 32'h01);
    frame(10, 32'h3A6);
    frame(3, 32'h5);
    // R4 chain frame
    frame(14, 32'h2C71);

    // R5 clocks with select high
    keep = code;
    c0 = upd_cnt;
    for (int i = 0; i < 5; i++) pulse_sclk(i[0]);
    check("R5 code hold", code, keep);
    check("R5 no upd", upd_cnt - c0, 0);

    // R6 preset then re-arm
    set_preset(1);
    frame(7, 32'h12);   // R7 transfer ignored under preset
    set_preset(0);
    check("R6 sdo released", sdo, 1);
    frame(7, 32'h6B);

    // R7 preset coincident with transfer
    csn = 1'b0;
    wait_n(4);
    for (int i = 6; i >= 0; i--) pulse_sclk(1'b1);
    c0 = upd_cnt;
    csn = 1'b1;
    pre_n = 1'b0;
    m_pre = 1; m_code = 7'h40; m_armed = 0;
    wait_n(6);
    check("R7 code", code, 7'h40);
    check("R7 upd", upd_cnt - c0, 1);
    set_preset(0);

    // R8/R9 sleep with write
    frame(7, 32'h33);
    set_sleep(1);
    frame(7, 32'h7E);
    set_sleep(0);
    check("R9 code after wake", code, 7'h7E);

    // random mix
    for (int k = 0; k < 40; k++) begin
      int unsigned r;
      r = $urandom;
      if (r[2:0] == 3'd0) set_preset(!m_pre);
      if (r[4:3] == 2'd0) set_sleep(!m_sleep);
      frame(1 + ($urandom % 16), $urandom);
    end
    if (m_pre) set_preset(0);
    if (m_sleep) set_sleep(0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule